// File: doc/BRIEF.md
# Binary Berlekamp Error-Locator Solver

This block takes the 2t syndromes of a binary BCH codeword over GF(2^M) and finds the error-locator polynomial sigma(x). Its roots mark the bit positions in error. A syndrome stage runs before it and a root search runs after it. The caller presents the syndromes, pulses a start input, and some cycles later receives the sigma coefficients, the polynomial degree and a one-cycle completion pulse.

The solver keeps a table of rows. Each row holds an index mu, a discrepancy d, an order, a delta value and one sigma polynomial. Row 0 starts as mu = -1, sigma = 1, d = 1, order 0. Row 1 starts as mu = 0, sigma = 1, d = S1, order 0. Iteration i (1..T) builds row i+1 and uses mu = 2i for that row.

If the discrepancy is zero, the row is copied forward and a zero-discrepancy counter is incremented. When this counter reaches a threshold that depends on the current order, the run ends early. If the discrepancy is nonzero, the solver picks an earlier reference row and adds a scaled, shifted copy of that row's polynomial to the current one. Field products and quotients are formed by adding and subtracting logarithms modulo 2^M-1. One iteration completes per clock cycle.

Top module: `bm_locator_solver`

## Requirements
- R1: After reset, done_o is 0, sigma_o is all zero and degree_o is 0.
- R2: The syndromes are captured in the cycle where start_i is accepted while idle. Later changes of syn_i have no effect on that run. A start_i pulse while a run is in progress is ignored and does not cause a second completion.
- R3: For any pattern of at most T bit errors at distinct positions p (locator value alpha^p, alpha = x modulo the primitive polynomial POLY), sigma_o equals the product of (1 + alpha^p x) over the errors. Coefficient k is at sigma_o[k*M +: M], and syndrome S_k is read from syn_i[(k-1)*M +: M]. The reference row chosen at each nonzero-discrepancy step is always an earlier row.
- R4: degree_o equals the order (half the doubled order) of the final row, which is the number of errors when there are at most T.
- R5: done_o is high for exactly one cycle per run. sigma_o and degree_o change only on the edge that raises done_o, and they are held after that.
- R6: All-zero syndromes give sigma = 1 and degree 0. The run ends early, at the iteration where the zero-discrepancy count equals floor(r/2) + (2 if r is odd, else 1), with r = T-1.
- R7: done_o rises no later than T clock edges after the edge that accepts start_i, and the iteration index stays within 1..T while running.
- R8: The constant coefficient of every result is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start a solve (accepted only while idle) |
| syn_i | input | 2*T*M | Syndromes S1..S2T, S_k at bits (k-1)*M |
| done_o | output | 1 | One-cycle completion pulse |
| sigma_o | output | (T+1)*M | Locator coefficients, coefficient k at bits k*M |
| degree_o | output | OW | Degree of the locator polynomial |

## Verification
The hardest situation to reach is the early exit through the zero-discrepancy counter combined with reference-row selection. It only happens when certain field sums cancel exactly, which random syndromes almost never do. The stimulus therefore builds syndromes from chosen error positions. Every run then holds a consistent, correctable pattern, with zero to T errors, and the cancellations, the early exits and the reference-row choices happen naturally. The directed cases add all-zero syndromes, for which the exit iteration is known exactly, and a start pulse with new syndromes in the middle of a run.

// File: rtl/bm_pkg.sv
// Package: constant Galois-field helpers used to build log/antilog tables
// at elaboration time. Assumes poly is primitive of degree m.
package bm_pkg;

    // Power of the primitive element: alpha^e reduced by poly.
    function automatic int gf_alog(int m, int poly, int e);
        int v;
        v = 1;
        for (int s = 0; s < e; s++) begin
            v = v << 1;
            if ((v & (1 << m)) != 0) v = v ^ poly;
        end
        return v;
    endfunction

    // Discrete log of v (returns 0 for v = 0, never used in that case).
    function automatic int gf_log(int m, int poly, int v);
        int r;
        r = 0;
        for (int e = 0; e < (1 << m) - 1; e++)
            if (gf_alog(m, poly, e) == v) r = e;
        return r;
    endfunction

endpackage

// File: rtl/bm_gf_muldiv.sv
// Module: computes a*b/c in GF(2^M) as a sum and difference of logs taken
// modulo 2^M-1. Output is zero if a or b is zero. Assumes c is nonzero.
module bm_gf_muldiv #(
    parameter int M    = 4,
    parameter int POLY = 19
) (
    input  logic [M-1:0] a_i,
    input  logic [M-1:0] b_i,
    input  logic [M-1:0] c_i,
    output logic [M-1:0] p_o
);
    localparam int N  = (1 << M) - 1;
    localparam int EW = M + 2;

    logic [M-1:0] alog_t [N];
    logic [M-1:0] log_t  [N+1];

    generate
        for (genvar g = 0; g < N; g++) begin : g_alog
            assign alog_t[g] = M'(bm_pkg::gf_alog(M, POLY, g));
        end
        for (genvar g = 0; g <= N; g++) begin : g_log
            assign log_t[g] = M'(bm_pkg::gf_log(M, POLY, g));
        end
    endgenerate

    logic [EW-1:0] sum0, sum1, sum2;

    // Log-domain multiply/divide with two conditional modulo reductions.
    always_comb begin
        sum0 = EW'(log_t[a_i]) + EW'(log_t[b_i]) + EW'(N) - EW'(log_t[c_i]);
        sum1 = (sum0 >= EW'(N)) ? sum0 - EW'(N) : sum0;
        sum2 = (sum1 >= EW'(N)) ? sum1 - EW'(N) : sum1;
        p_o  = (a_i == '0 || b_i == '0) ? '0 : alog_t[M'(sum2)];
    end
endmodule

// File: rtl/bm_ref_select.sv
// Module: picks the reference row, the earlier row (index below cur_i) with
// a nonzero discrepancy and the strictly largest delta. Defaults to row 0.
module bm_ref_select #(
    parameter int T  = 3,
    parameter int M  = 4,
    parameter int RW = 3,
    parameter int DW = 6
) (
    input  logic [RW-1:0]        cur_i,
    input  logic [M-1:0]         dsc_i [T+2],
    input  logic signed [DW-1:0] dlt_i [T+2],
    output logic [RW-1:0]        ro_o
);
    logic signed [DW-1:0] best;

    // Scan earlier rows for the largest delta among nonzero discrepancies.
    always_comb begin
        best = '1;
        ro_o = '0;
        for (int j = 0; j < T + 2; j++) begin
            if (RW'(j) < cur_i && dsc_i[j] != '0 && dlt_i[j] > best) begin
                best = dlt_i[j];
                ro_o = RW'(j);
            end
        end
    end
endmodule

// File: rtl/bm_row_step.sv
// Module: one Berlekamp iteration. It builds row i+1 (sigma, order, delta)
// from row i and the reference row, then the discrepancy of row i+1.
// Assumes ro_i < cur_i and cur_i >= 1. Returns a zero discrepancy when cur_i >= T.
module bm_row_step #(
    parameter int T    = 3,
    parameter int M    = 4,
    parameter int POLY = 19,
    parameter int RW   = 3,
    parameter int OW   = 4,
    parameter int DW   = 6
) (
    input  logic [RW-1:0]        cur_i,
    input  logic [RW-1:0]        ro_i,
    input  logic [M-1:0]         syn_i     [2*T],
    input  logic [M-1:0]         sig_cur_i [T+1],
    input  logic [OW-1:0]        ord_cur_i,
    input  logic [M-1:0]         dsc_cur_i,
    input  logic [M-1:0]         sig_ref_i [T+1],
    input  logic [OW-1:0]        ord_ref_i,
    input  logic [M-1:0]         dsc_ref_i,
    output logic [M-1:0]         sig_nxt_o [T+1],
    output logic [OW-1:0]        ord_nxt_o,
    output logic signed [DW-1:0] dlt_nxt_o,
    output logic [M-1:0]         dsc_nxt_o
);
    logic [M-1:0] term [T+1];
    logic [M-1:0] ssel [T];
    logic [M-1:0] prod [T];

    // Scaled reference terms d_i * sigma_ro[k] / d_ro.
    generate
        for (genvar k = 0; k <= T; k++) begin : g_term
            bm_gf_muldiv #(.M(M), .POLY(POLY)) i_term (
                .a_i(dsc_cur_i), .b_i(sig_ref_i[k]), .c_i(dsc_ref_i), .p_o(term[k])
            );
        end
    endgenerate

    int mu_c, mu_r, df, o_new;

    // Copy or update sigma and its order, then the delta of the new row.
    always_comb begin
        mu_c = 2 * (int'(cur_i) - 1);
        mu_r = (ro_i == '0) ? -1 : 2 * (int'(ro_i) - 1);
        df   = mu_c - mu_r;
        for (int k = 0; k <= T; k++) sig_nxt_o[k] = sig_cur_i[k];
        o_new = int'(ord_cur_i);
        if (dsc_cur_i != '0) begin
            if (int'(ord_cur_i) <= int'(ord_ref_i) + df) o_new = int'(ord_ref_i) + df;
            for (int k = 0; k <= T; k++)
                if (k + df <= T) sig_nxt_o[k + df] = sig_nxt_o[k + df] ^ term[k];
        end
        ord_nxt_o = OW'(o_new);
        dlt_nxt_o = DW'(2 * int'(cur_i) - o_new);
    end

    int sx;

    // Select syndrome S_(2i+1-k) for each product term, zero if out of range.
    always_comb begin
        for (int k = 1; k <= T; k++) begin
            sx = 2 * int'(cur_i) + 1 - k;
            ssel[k-1] = (sx >= 1 && sx <= 2 * T) ? syn_i[sx-1] : '0;
        end
    end

    generate
        for (genvar k = 1; k <= T; k++) begin : g_prod
            bm_gf_muldiv #(.M(M), .POLY(POLY)) i_prod (
                .a_i(sig_nxt_o[k]), .b_i(ssel[k-1]), .c_i(M'(1)), .p_o(prod[k-1])
            );
        end
    endgenerate

    // Next discrepancy, skipped on the last iteration.
    always_comb begin
        dsc_nxt_o = '0;
        if (int'(cur_i) < T) begin
            dsc_nxt_o = syn_i[2 * int'(cur_i)];
            for (int k = 0; k < T; k++) dsc_nxt_o = dsc_nxt_o ^ prod[k];
        end
    end
endmodule

// File: rtl/bm_locator_solver.sv
// Module: top of the error-locator solver. It holds the row table, runs one
// iteration per clock, applies the zero-discrepancy early exit and registers
// the result. Assumes POLY is primitive of degree M and T >= 1.
module bm_locator_solver #(
    parameter int M    = 4,
    parameter int POLY = 19,
    parameter int T    = 3,
    localparam int RN  = T + 2,
    localparam int RW  = $clog2(T + 2),
    localparam int OW  = $clog2(2 * T + 3),
    localparam int DW  = OW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [2*T*M-1:0]     syn_i,
    output logic                 done_o,
    output logic [(T+1)*M-1:0]   sigma_o,
    output logic [OW-1:0]        degree_o
);
    logic                 run_q;
    logic [RW-1:0]        it_q, zc_q, ro_w;
    logic [M-1:0]         syn_q [2*T];
    logic [M-1:0]         sig_q [RN][T+1];
    logic [OW-1:0]        ord_q [RN];
    logic [M-1:0]         dsc_q [RN];
    logic signed [DW-1:0] dlt_q [RN];

    logic [M-1:0]         sig_c [T+1];
    logic [M-1:0]         sig_r [T+1];
    logic [M-1:0]         sig_n [T+1];
    logic [OW-1:0]        ord_n;
    logic signed [DW-1:0] dlt_n;
    logic [M-1:0]         dsc_n;
    logic                 zero_exit;
    int                   rem, thr;

    // Fetch the current and reference rows from the table.
    always_comb begin
        for (int k = 0; k <= T; k++) begin
            sig_c[k] = sig_q[it_q][k];
            sig_r[k] = sig_q[ro_w][k];
        end
    end

    // Early-exit test: the zero-discrepancy count reaches the order-based threshold.
    always_comb begin
        rem = T - int'(ord_q[it_q]) - 1;
        thr = (rem >= 0) ? (rem / 2 + (((rem % 2) != 0) ? 2 : 1)) : 0;
        zero_exit = run_q && (dsc_q[it_q] == '0) && (int'(zc_q) + 1 == thr);
    end

    bm_ref_select #(.T(T), .M(M), .RW(RW), .DW(DW)) i_sel (
        .cur_i(it_q), .dsc_i(dsc_q), .dlt_i(dlt_q), .ro_o(ro_w)
    );

    bm_row_step #(.T(T), .M(M), .POLY(POLY), .RW(RW), .OW(OW), .DW(DW)) i_step (
        .cur_i(it_q), .ro_i(ro_w), .syn_i(syn_q),
        .sig_cur_i(sig_c), .ord_cur_i(ord_q[it_q]), .dsc_cur_i(dsc_q[it_q]),
        .sig_ref_i(sig_r), .ord_ref_i(ord_q[ro_w]), .dsc_ref_i(dsc_q[ro_w]),
        .sig_nxt_o(sig_n), .ord_nxt_o(ord_n), .dlt_nxt_o(dlt_n), .dsc_nxt_o(dsc_n)
    );

    // Sequencer: load rows 0 and 1 on start, then run one row per cycle and register the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            it_q     <= '0;
            zc_q     <= '0;
            done_o   <= 1'b0;
            sigma_o  <= '0;
            degree_o <= '0;
            for (int k = 0; k < 2 * T; k++) syn_q[k] <= '0;
            for (int r = 0; r < RN; r++) begin
                ord_q[r] <= '0;
                dsc_q[r] <= '0;
                dlt_q[r] <= '0;
                for (int k = 0; k <= T; k++) sig_q[r][k] <= '0;
            end
        end else begin
            done_o <= 1'b0;
            if (!run_q) begin
                if (start_i) begin
                    for (int k = 0; k < 2 * T; k++) syn_q[k] <= syn_i[k*M +: M];
                    for (int r = 0; r < 2; r++)
                        for (int k = 0; k <= T; k++) sig_q[r][k] <= (k == 0) ? M'(1) : '0;
                    ord_q[0] <= '0;
                    ord_q[1] <= '0;
                    dsc_q[0] <= M'(1);
                    dsc_q[1] <= syn_i[M-1:0];
                    dlt_q[0] <= '1;
                    dlt_q[1] <= '0;
                    it_q     <= RW'(1);
                    zc_q     <= '0;
                    run_q    <= 1'b1;
                end
            end else if (zero_exit) begin
                for (int k = 0; k <= T; k++) sigma_o[k*M +: M] <= sig_c[k];
                degree_o <= ord_q[it_q];
                done_o   <= 1'b1;
                run_q    <= 1'b0;
            end else begin
                for (int k = 0; k <= T; k++) sig_q[it_q + RW'(1)][k] <= sig_n[k];
                ord_q[it_q + RW'(1)] <= ord_n;
                dlt_q[it_q + RW'(1)] <= dlt_n;
                dsc_q[it_q + RW'(1)] <= dsc_n;
                if (dsc_q[it_q] == '0) zc_q <= zc_q + RW'(1);
                if (it_q == RW'(T)) begin
                    for (int k = 0; k <= T; k++) sigma_o[k*M +: M] <= sig_n[k];
                    degree_o <= ord_n;
                    done_o   <= 1'b1;
                    run_q    <= 1'b0;
                end else begin
                    it_q <= it_q + RW'(1);
                end
            end
        end
    end

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(sigma_o) && $stable(degree_o)));

    // R8
    unit_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (sigma_o[M-1:0] == M'(1)));

    // R7
    iter_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (it_q >= RW'(1) && it_q <= RW'(T)));

    // R3
    ref_earlier_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (ro_w < it_q));
endmodule

// File: tb/test_bm_locator_solver.sv
`timescale 1ns/1ps
module test_bm_locator_solver;
    localparam int M    = 4;
    localparam int POLY = 19;
    localparam int T    = 3;
    localparam int N    = (1 << M) - 1;
    localparam int OW   = $clog2(2 * T + 3);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start_i = 1'b0;
    logic [2*T*M-1:0]     syn_i = '0;
    logic                 done_o;
    logic [(T+1)*M-1:0]   sigma_o;
    logic [OW-1:0]        degree_o;

    int checks = 0;
    int errors = 0;

    bm_locator_solver #(.M(M), .POLY(POLY), .T(T)) i_bm_locator_solver (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .syn_i(syn_i),
        .done_o(done_o), .sigma_o(sigma_o), .degree_o(degree_o)
    );

    always #2 clk = ~clk;

    function automatic int gmul(int a, int b);
        int r;
        r = 0;
        for (int i = 0; i < M; i++) if (((b >> i) & 1) != 0) r = r ^ (a << i);
        for (int i = 2 * M - 2; i >= M; i--) if (((r >> i) & 1) != 0) r = r ^ (POLY << (i - M));
        return r;
    endfunction

    function automatic int gpow(int x, int e);
        int v;
        v = 1;
        for (int i = 0; i < e; i++) v = gmul(v, x);
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    logic [(T+1)*M-1:0] exp_sig;
    logic [2*T*M-1:0]   mk_syn;

    // Builds syndromes and expected locator from error positions.
    task automatic build(input int ne, input int pos [T]);
        int poly [T+1];
        int x;
        for (int k = 0; k <= T; k++) poly[k] = (k == 0) ? 1 : 0;
        mk_syn = '0;
        for (int j = 0; j < ne; j++) begin
            x = gpow(2, pos[j]);
            for (int k = 1; k <= 2 * T; k++)
                mk_syn[(k-1)*M +: M] = mk_syn[(k-1)*M +: M] ^ M'(gpow(x, k));
            for (int k = T; k >= 1; k--) poly[k] = poly[k] ^ gmul(x, poly[k-1]);
        end
        for (int k = 0; k <= T; k++) exp_sig[k*M +: M] = M'(poly[k]);
    endtask

    // Starts a run and waits for done; lat counts edges after the accepting edge.
    task automatic run(output int lat);
        @(negedge clk);
        syn_i   = mk_syn;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (!done_o && lat < 40) begin
            lat++;
            @(negedge clk);
        end
    endtask

    task automatic solve_check(input int ne, input int pos [T]);
        int lat;
        build(ne, pos);
        run(lat);
        check(done_o == 1'b1 && lat <= T, "R7 latency", lat, T);
        check(sigma_o == exp_sig, "R3 sigma", int'(sigma_o), int'(exp_sig));
        check(int'(degree_o) == ne, "R4 degree", int'(degree_o), ne);
        @(negedge clk);
        check(done_o == 1'b0, "R5 pulse", int'(done_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R7 watchdog expired: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int pos [T];
        int lat, ne, rr, thr0;
        logic [(T+1)*M-1:0] held_sig;
        logic [OW-1:0]      held_deg;
        bit dup, seen;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(done_o == 1'b0, "R1 done", int'(done_o), 0);
        check(sigma_o == '0, "R1 sigma", int'(sigma_o), 0);
        check(degree_o == '0, "R1 degree", int'(degree_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 zero syndromes: early exit
        for (int j = 0; j < T; j++) pos[j] = 0;
        build(0, pos);
        run(lat);
        rr   = T - 1;
        thr0 = rr / 2 + (((rr % 2) != 0) ? 2 : 1);
        if (thr0 > T) thr0 = T;
        check(lat == thr0, "R6 exit cycle", lat, thr0);
        check(sigma_o == exp_sig, "R6 sigma", int'(sigma_o), int'(exp_sig));
        check(degree_o == '0, "R6 degree", int'(degree_o), 0);

        // R3 directed single errors at both ends and T adjacent errors
        pos[0] = 0;      solve_check(1, pos);
        pos[0] = N - 1;  solve_check(1, pos);
        for (int j = 0; j < T; j++) pos[j] = 4 + j;
        solve_check(T, pos);

        // R5 result held after done while syn_i moves and no start arrives
        held_sig = sigma_o;
        held_deg = degree_o;
        syn_i = ~syn_i;
        repeat (6) @(negedge clk);
        check(sigma_o == held_sig, "R5 hold sigma", int'(sigma_o), int'(held_sig));
        check(degree_o == held_deg, "R5 hold degree", int'(degree_o), int'(held_deg));

        // R2 new syndromes and a start pulse during a run are ignored
        pos[0] = 2; pos[1] = 9;
        build(2, pos);
        @(negedge clk);
        syn_i   = mk_syn;
        start_i = 1'b1;
        @(negedge clk);
        syn_i   = ~mk_syn;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 40) begin
            lat++;
            @(negedge clk);
        end
        check(sigma_o == exp_sig, "R2 captured syndromes", int'(sigma_o), int'(exp_sig));
        check(int'(degree_o) == 2, "R2 degree", int'(degree_o), 2);
        seen = 1'b0;
        repeat (T + 3) begin
            @(negedge clk);
            if (done_o) seen = 1'b1;
        end
        check(!seen, "R2 no second completion", int'(seen), 0);

        // R3 R4 R7 random correctable patterns
        for (int t = 0; t < 150; t++) begin
            ne = int'($urandom % (T + 1));
            for (int j = 0; j < ne; j++) begin
                do begin
                    pos[j] = int'($urandom % N);
                    dup = 1'b0;
                    for (int q = 0; q < j; q++) if (pos[q] == pos[j]) dup = 1'b1;
                end while (dup);
            end
            solve_check(ne, pos);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule